// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

A countdown watchdog that sits on a simple register bus (address, write enable, write data, read enable, registered read data). Software loads a reload value, then turns on counting. While counting is on, the count falls by one every clock. When the count is zero at a clock edge, the timer expires: the count refills from the reload value and a sticky timeout flag is set.

An expiry can drive a level interrupt, a system reset pulse of programmable length, or both. Each has its own enable bit. Software keeps the timer from expiring by writing a fixed key to the restart register. That write refills the count without counting as an expiry. A write of any other value to the restart register is ignored. The timeout flag stays set until software writes to the timeout-clear register.

Top module: `wdt_top`

## Requirements
- R1: After a synchronous reset, the control register reads 0, the reload and status registers read all ones (CNT_W bits, zero-extended), the timeout flag reads 0, and both `irq_o` and `sys_rst_o` are low.
- R2: Reads return data one clock after the read strobe. The word offsets are: status 0x00, reload 0x04, restart 0x08, control 0x0C, timeout 0x10 (flag in bit 0), timeout-clear 0x14 and reset-width 0x18. The reload, control and reset-width registers read back the written value, truncated to CNT_W, 3 and RSTW_W bits. The restart and timeout-clear registers always read 0.
- R3: Control bit 0 is the run bit. A control write that takes it from 0 to 1 loads the count from the reload register. While the run bit is 1, the count falls by one every clock.
- R4: While the run bit is 0, the count holds its value and no expiry occurs. Only a restart or a fresh enable can change the count.
- R5: A write of exactly 0x00004755 to the restart register loads the count from the reload register. A write of any other value there has no effect.
- R6: A valid restart never produces an expiry, even when the count is zero in that cycle.
- R7: While running, a count of zero at a clock edge is an expiry. The count reloads and the timeout flag is set.
- R8: `irq_o` equals the timeout flag ANDed with control bit 2, delayed by one register. Any write to the timeout-clear register clears the flag. An expiry in the same cycle wins over the clear.
- R9: On an expiry with control bit 1 set, `sys_rst_o` rises at the same edge. It stays high for max(W,1) clocks, where W is the reset-width value. A new expiry during a pulse restarts the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the clock after `bus_re` |
| irq_o | output | 1 | Level interrupt |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with CNT_W = 16 and RSTW_W = 4, keeping ADDR_W = 8 and DATA_W = 32. With a counter narrower than the bus, the zero-extension of the status and reload reads can be observed. It also makes the all-ones reset value a distinct pattern, 0x0000FFFF. A 4-bit reset-width field makes truncation of wider writes visible. Small reload values (1 to 10) let the bench reach every expiry, every pulse edge and the case where a restart meets a zero count, all within a few dozen clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Register byte offsets (software-visible map)
  localparam int OFF_STATUS  = 'h00;
  localparam int OFF_RELOAD  = 'h04;
  localparam int OFF_RESTART = 'h08;
  localparam int OFF_CTRL    = 'h0C;
  localparam int OFF_TMO     = 'h10;
  localparam int OFF_TMO_CLR = 'h14;
  localparam int OFF_RST_W   = 'h18;

  // Only this exact value re-arms the counter
  localparam int RESTART_KEY = 'h4755;

  // Control field: bit2 interrupt enable, bit1 reset enable, bit0 run
  typedef struct packed {
    logic irq_en;
    logic rst_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int RSTW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [RSTW_W-1:0] rstw_o,
  output logic              flag_o,
  output logic              load_o,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFF_RESTART);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_TMO     = ADDR_W'(OFF_TMO);
  localparam logic [ADDR_W-1:0] A_TMO_CLR = ADDR_W'(OFF_TMO_CLR);
  localparam logic [ADDR_W-1:0] A_RST_W   = ADDR_W'(OFF_RST_W);
  localparam logic [DATA_W-1:0] KEY       = DATA_W'(RESTART_KEY);

  logic wr_reload, wr_ctrl, wr_rstw, wr_clr, key_hit, run_rise;
  ctrl_t wr_ctrl_val;

  assign wr_reload   = bus_we && (bus_addr == A_RELOAD);
  assign wr_ctrl     = bus_we && (bus_addr == A_CTRL);
  assign wr_rstw     = bus_we && (bus_addr == A_RST_W);
  assign wr_clr      = bus_we && (bus_addr == A_TMO_CLR);
  assign key_hit     = bus_we && (bus_addr == A_RESTART) && (bus_wdata == KEY);
  assign wr_ctrl_val = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  assign run_rise    = wr_ctrl && wr_ctrl_val.run && !ctrl_o.run;
  assign load_o      = run_rise || key_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o   <= '0;
      reload_o <= '1;
      rstw_o   <= '0;
    end else begin
      if (wr_ctrl)   ctrl_o   <= wr_ctrl_val;
      if (wr_reload) reload_o <= bus_wdata[CNT_W-1:0];
      if (wr_rstw)   rstw_o   <= bus_wdata[RSTW_W-1:0];
    end
  end

  // Sticky timeout flag: a new expiry wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)           flag_o <= 1'b0;
    else if (expire_i) flag_o <= 1'b1;
    else if (wr_clr)   flag_o <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        A_STATUS: bus_rdata <= DATA_W'(count_i);
        A_RELOAD: bus_rdata <= DATA_W'(reload_o);
        A_CTRL:   bus_rdata <= DATA_W'(ctrl_o);
        A_TMO:    bus_rdata <= DATA_W'(flag_o);
        A_RST_W:  bus_rdata <= DATA_W'(rstw_o);
        default:  bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);

  logic at_zero;
  assign at_zero  = (count_o == '0);
  // A load (keyed restart or fresh enable) pre-empts expiry
  assign expire_o = run_i && !load_i && at_zero;

  always_ff @(posedge clk) begin
    if (rst)                count_o <= '1;
    else if (load_i)        count_o <= reload_i;
    else if (run_i) begin
      if (at_zero)          count_o <= reload_i;
      else                  count_o <= count_o - 1'b1;
    end
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int RSTW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [RSTW_W-1:0] width_i,
  output logic              pulse_o
);

  logic [RSTW_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      remain  <= '0;
    end else if (trig_i) begin
      pulse_o <= 1'b1;
      remain  <= (width_i == '0) ? '0 : width_i - 1'b1;
    end else if (remain != '0) begin
      remain  <= remain - 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int RSTW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  count;
  logic [RSTW_W-1:0] rstw;
  logic              flag, load, expire;

  wdt_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RSTW_W(RSTW_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .count_i(count), .expire_i(expire),
    .ctrl_o(ctrl), .reload_o(reload), .rstw_o(rstw), .flag_o(flag),
    .load_o(load), .bus_rdata(bus_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst),
    .run_i(ctrl.run), .load_i(load), .reload_i(reload),
    .count_o(count), .expire_o(expire)
  );

  wdt_pulse #(.RSTW_W(RSTW_W)) pulse_i (
    .clk(clk), .rst(rst),
    .trig_i(expire && ctrl.rst_en), .width_i(rstw),
    .pulse_o(sys_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= flag && ctrl.irq_en;
  end

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic              sys_rst_o,
  input ctrl_t             ctrl,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic              flag,
  input logic              expire,
  input logic              load
);

  logic key_wr;
  assign key_wr = bus_we && (bus_addr == ADDR_W'(OFF_RESTART))
                  && (bus_wdata == DATA_W'(RESTART_KEY));

  assert_key_reload_R5: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> count == $past(reload));

  assert_key_no_expiry_R6: assert property (@(posedge clk) disable iff (rst)
    key_wr |-> !expire);

  assert_halt_no_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.run |-> !expire);

  assert_halt_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !load) |=> $stable(count));

  assert_expiry_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(flag && ctrl.irq_en));

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(expire && ctrl.rst_en));

endmodule

bind wdt_top wdt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .sys_rst_o(sys_rst_o), .ctrl(ctrl), .count(count), .reload(reload),
  .flag(flag), .expire(expire), .load(load)
);

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int RSTW_W = 4;

  localparam logic [7:0] S_STATUS = 8'h00, S_RELOAD = 8'h04, S_RESTART = 8'h08,
                         S_CTRL = 8'h0C, S_TMO = 8'h10, S_CLR = 8'h14, S_RSTW = 8'h18;
  localparam logic [31:0] KEY = 32'h0000_4755;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic irq_o, sys_rst_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RSTW_W(RSTW_W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  // Vector: {is_read, addr, wdata, expected}; run with the counter halted
  localparam int NV = 17;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, S_STATUS,  32'h0,           32'h0000_FFFF},  // R1
    {1'b1, S_RELOAD,  32'h0,           32'h0000_FFFF},  // R1
    {1'b1, S_CTRL,    32'h0,           32'h0},          // R1
    {1'b1, S_TMO,     32'h0,           32'h0},          // R1
    {1'b0, S_RELOAD,  32'h0001_2345,   32'h0},
    {1'b1, S_RELOAD,  32'h0,           32'h0000_2345},  // R2 truncation
    {1'b0, S_RSTW,    32'h0000_0035,   32'h0},
    {1'b1, S_RSTW,    32'h0,           32'h0000_0005},  // R2
    {1'b0, S_CTRL,    32'hFFFF_FFF6,   32'h0},
    {1'b1, S_CTRL,    32'h0,           32'h0000_0006},  // R2
    {1'b1, S_STATUS,  32'h0,           32'h0000_FFFF},  // R4 halted
    {1'b1, S_RESTART, 32'h0,           32'h0},          // R2
    {1'b1, S_CLR,     32'h0,           32'h0},          // R2
    {1'b0, S_CTRL,    32'h0000_0000,   32'h0},
    {1'b1, S_CTRL,    32'h0,           32'h0},          // R2
    {1'b0, S_RESTART, KEY,             32'h0},
    {1'b1, S_STATUS,  32'h0,           32'h0000_2345}   // R5 restart while halted
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 1'b0;
    check("R1 irq", 32'(irq_o), 0);
    check("R1 rst", 32'(sys_rst_o), 0);
    check("R1 rdata", bus_rdata, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        rd(VEC[i][71:64], d);
        check($sformatf("R1/R2 vector %0d", i), d, VEC[i][31:0]);
      end else begin
        wr(VEC[i][71:64], VEC[i][63:32]);
      end
    end

    // R3: enable loads, then decrement per clock
    wr(S_RELOAD, 10);
    wr(S_CTRL, 1);
    rd(S_STATUS, d); check("R3 load on enable", d, 10);
    rd(S_STATUS, d); check("R3 decrement", d, 9);
    wr(S_CTRL, 0);
    rd(S_STATUS, d); check("R4 frozen", d, 7);
    rd(S_STATUS, d); check("R4 frozen again", d, 7);
    rd(S_TMO, d);    check("R4 no event", d, 0);

    // R5: wrong key ignored, right key reloads
    wr(S_CTRL, 1);
    wr(S_RESTART, 32'h0000_1234);
    rd(S_STATUS, d); check("R5 bad key", d, 9);
    wr(S_RESTART, KEY);
    rd(S_STATUS, d); check("R5 good key", d, 10);

    // R6: restart while count is zero gives no expiry
    wr(S_CTRL, 0);
    wr(S_RELOAD, 2);
    wr(S_CTRL, 1);
    idle(2);
    wr(S_RESTART, KEY);
    wr(S_CTRL, 0);
    rd(S_TMO, d);    check("R6 no timeout", d, 0);
    rd(S_STATUS, d); check("R6 reloaded", d, 1);

    // R7/R8/R9: expiry with interrupt and reset enabled, width 2
    wr(S_RELOAD, 3);
    wr(S_RSTW, 2);
    wr(S_CTRL, 7);
    idle(3);
    check("R9 before expiry", 32'(sys_rst_o), 0);
    check("R8 before expiry", 32'(irq_o), 0);
    idle(1);
    check("R9 pulse rise", 32'(sys_rst_o), 1);
    check("R8 irq lag", 32'(irq_o), 0);
    idle(1);
    check("R9 pulse cycle 2", 32'(sys_rst_o), 1);
    check("R8 irq up", 32'(irq_o), 1);
    idle(1);
    check("R9 pulse end", 32'(sys_rst_o), 0);
    wr(S_CTRL, 4);
    check("R8 irq held", 32'(irq_o), 1);
    rd(S_TMO, d);    check("R7 flag set", d, 1);
    wr(S_CLR, 32'h0);
    check("R8 irq before clear lands", 32'(irq_o), 1);
    idle(1);
    check("R8 irq cleared", 32'(irq_o), 0);
    rd(S_TMO, d);    check("R8 flag cleared", d, 0);

    // R7/R8: expiry with outputs disabled; count reloads
    wr(S_RELOAD, 1);
    wr(S_CTRL, 1);
    idle(3);
    check("R8 irq masked", 32'(irq_o), 0);
    check("R9 reset masked", 32'(sys_rst_o), 0);
    wr(S_CTRL, 0);
    rd(S_TMO, d);    check("R7 flag", d, 1);
    rd(S_STATUS, d); check("R7 reloaded", d, 1);
    wr(S_CLR, 32'h0);

    // R9: width 0 gives a one-clock pulse
    wr(S_RSTW, 0);
    wr(S_CTRL, 3);
    idle(2);
    check("R9 min pulse high", 32'(sys_rst_o), 1);
    idle(1);
    check("R9 min pulse low", 32'(sys_rst_o), 0);
    wr(S_CTRL, 0);

    done = 1'b1;
    finish_run();
  end

endmodule